// File: doc/BRIEF.md
# Parallel Printer Output Controller

This block bridges a host processor and a character printer. The host sees two byte-wide registers behind one address bit: a status word whose top bit says whether the controller can take a character, and a buffer that holds the character to print. Writing the buffer starts a transfer. The controller then waits until the printer signals ready. It presents the byte on the printer data lines and pulses a strobe for one clock.

The host can learn that the controller is free in two ways. In polling operation it reads the status word and tests bit 7. In interrupt operation the controller also raises a level interrupt when a character has been handed over. The host is expected to stay away until that interrupt arrives. The printer side works like a stream: the strobe is the valid beat and the printer's ready input is the back-pressure. No byte moves while ready is low, and the pending character waits in the buffer for as long as needed. Everything runs on one clock with a synchronous active-high reset.

Top module: `prn_out_ctrl`

## Requirements
- R1: A synchronous reset sets status to 8'h81 and the buffer to 8'h00, and clears the interrupt, the strobe and the printer data lines. This holds both at start-up and in the middle of a transfer.
- R2: A read has host_cs=1 and host_we=0. With host_sel=0 it shows the status word on host_rdata in the same cycle, and with host_sel=1 it shows the buffer. A read changes no state.
- R3: A write has host_cs=1, host_we=1 and host_sel=1. If the controller is ready, the write stores host_wdata into the buffer, and from the next cycle the status reads 8'h00.
- R4: While the status is 8'h00 and prn_ready is 0, prn_strobe stays 0 and the status stays 8'h00.
- R5: While busy, the first clock edge that samples prn_ready=1 loads the buffer onto prn_data and raises prn_strobe for exactly one cycle.
- R6: On the edge that raises prn_strobe, the status becomes 8'h81.
- R7: If irq_mode=1 on the edge that raises prn_strobe, host_irq goes to 1 on that edge and stays 1 until the next accepted buffer write, which clears it.
- R8: If irq_mode=0 on the edge that raises prn_strobe, host_irq stays 0.
- R9: With host_cs=0, host_rdata is 8'h00 and writes have no effect.
- R10: prn_data only changes on an edge that raises prn_strobe, or on reset.
- R11: Writes with host_sel=0 leave the status unchanged. Buffer writes made while busy are dropped, and the buffer keeps the pending character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_cs | input | 1 | Chip select, active high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 1 | 0 = status word, 1 = buffer |
| irq_mode | input | 1 | 1 = interrupt operation, 0 = polling |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, 0 when not reading |
| host_irq | output | 1 | Level interrupt: ready for the next character |
| prn_data | output | 8 | Character to the printer |
| prn_ready | input | 1 | Printer ready for a character |
| prn_strobe | output | 1 | One-cycle transfer request |

## Verification
The assertions assume that prn_ready is a clean synchronous level. They also assume that irq_mode is valid on every edge that completes a transfer. They do not need the host to keep quiet while busy, because such writes are defined to be dropped. The stimulus changes every input only at the falling clock edge. It also tries buffer writes during a busy period on purpose, so the drop rule is exercised, not just assumed.

// File: rtl/prn_pkg.sv
package prn_pkg;
  typedef enum logic {
    XF_IDLE = 1'b0,
    XF_WAIT = 1'b1
  } xfer_state_t;

  function automatic int ready_word(input int w);
    return (1 << (w - 1)) | 1;
  endfunction
endpackage

// File: rtl/prn_regs.sv
module prn_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          we,
  input  logic          sel,
  input  logic [DW-1:0] wdata,
  input  logic          busy,
  input  logic [DW-1:0] status,
  output logic [DW-1:0] buf_q,
  output logic          buf_load,
  output logic [DW-1:0] rdata
);
  logic rd_en;

  assign buf_load = cs & we & sel & ~busy;
  assign rd_en    = cs & ~we;

  always_ff @(posedge clk) begin
    if (rst)           buf_q <= '0;
    else if (buf_load) buf_q <= wdata;
  end

  always_comb begin
    rdata = '0;
    if (rd_en) rdata = sel ? buf_q : status;
  end

  assert_buf_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!cs || !we || !sel || busy) |=> $stable(buf_q));
  assert_quiet_bus_R9: assert property (@(posedge clk) disable iff (rst)
    !cs |-> (rdata == '0));
endmodule

// File: rtl/prn_xfer.sv
module prn_xfer
  import prn_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] buf_q,
  input  logic          ready,
  input  logic          mode,
  output logic [DW-1:0] status,
  output logic          busy,
  output logic          strobe,
  output logic [DW-1:0] pdata,
  output logic          irq
);
  localparam logic [DW-1:0] SR_READY = DW'(ready_word(DW));

  xfer_state_t state;

  assign busy = (state == XF_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= XF_IDLE;
      status <= SR_READY;
      strobe <= 1'b0;
      pdata  <= '0;
      irq    <= 1'b0;
    end else begin
      strobe <= 1'b0;
      unique case (state)
        XF_IDLE: if (start) begin
          state  <= XF_WAIT;
          status <= '0;
          irq    <= 1'b0;
        end
        XF_WAIT: if (ready) begin
          pdata  <= buf_q;
          strobe <= 1'b1;
          status <= SR_READY;
          irq    <= mode;
          state  <= XF_IDLE;
        end
        default: state <= XF_IDLE;
      endcase
    end
  end

  assert_strobe_width_R5: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);
  assert_strobe_gated_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe) |-> ($past(ready) && $past(busy)));
  assert_wait_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && !ready) |=> (status == '0 && !strobe));
  assert_ready_word_R6: assert property (@(posedge clk) disable iff (rst)
    strobe |-> (status == SR_READY));
  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (strobe && $past(mode)));
  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (irq && !start) |=> irq);
  assert_poll_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && ready && !mode) |=> !irq);
  assert_pdata_stable_R10: assert property (@(posedge clk) disable iff (rst)
    !strobe |-> $stable(pdata));
endmodule

// File: rtl/prn_out_ctrl.sv
module prn_out_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_cs,
  input  logic          host_we,
  input  logic          host_sel,
  input  logic          irq_mode,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_irq,
  output logic [DW-1:0] prn_data,
  input  logic          prn_ready,
  output logic          prn_strobe
);
  logic [DW-1:0] status, buf_q;
  logic          buf_load, busy;

  prn_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .cs(host_cs), .we(host_we), .sel(host_sel),
    .wdata(host_wdata), .busy(busy), .status(status),
    .buf_q(buf_q), .buf_load(buf_load), .rdata(host_rdata)
  );

  prn_xfer #(.DW(DW)) u_xfer (
    .clk(clk), .rst(rst), .start(buf_load), .buf_q(buf_q),
    .ready(prn_ready), .mode(irq_mode), .status(status), .busy(busy),
    .strobe(prn_strobe), .pdata(prn_data), .irq(host_irq)
  );

  assert_sel_status_R11: assert property (@(posedge clk) disable iff (rst)
    (host_cs && host_we && !host_sel && !busy) |=> !busy);
endmodule

// File: tb/prn_out_ctrl_bench.sv
module prn_out_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, we = 1'b0, sel = 1'b0, mode = 1'b0, rdy = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] rd_q, pd;
  logic irq, stb;
  int checks = 0;
  int errors = 0;
  logic [7:0] v;

  always #4 clk = ~clk;

  prn_out_ctrl u_prn_out_ctrl (
    .clk(clk), .rst(rst), .host_cs(cs), .host_we(we), .host_sel(sel),
    .irq_mode(mode), .host_wdata(wd), .host_rdata(rd_q), .host_irq(irq),
    .prn_data(pd), .prn_ready(rdy), .prn_strobe(stb)
  );

  // fields: cs we sel din[8] rdy mode | strobe irq pd[8]
  localparam logic [22:0] VEC [11] = '{
    {1'b1,1'b1,1'b1,8'h41,1'b0,1'b1, 1'b0,1'b0,8'h00},
    {1'b0,1'b0,1'b0,8'h00,1'b0,1'b1, 1'b0,1'b0,8'h00},
    {1'b0,1'b0,1'b0,8'h00,1'b1,1'b1, 1'b1,1'b1,8'h41},
    {1'b0,1'b0,1'b0,8'h00,1'b1,1'b1, 1'b0,1'b1,8'h41},
    {1'b1,1'b1,1'b1,8'h5A,1'b1,1'b0, 1'b0,1'b0,8'h41},
    {1'b0,1'b0,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b0,8'h5A},
    {1'b0,1'b0,1'b0,8'h00,1'b0,1'b0, 1'b0,1'b0,8'h5A},
    {1'b1,1'b1,1'b1,8'hC3,1'b1,1'b1, 1'b0,1'b0,8'h5A},
    {1'b1,1'b1,1'b1,8'h11,1'b0,1'b1, 1'b0,1'b0,8'h5A},
    {1'b0,1'b0,1'b0,8'h00,1'b1,1'b1, 1'b1,1'b1,8'hC3},
    {1'b0,1'b0,1'b0,8'h00,1'b1,1'b1, 1'b0,1'b1,8'hC3}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cs = 1'b0; we = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic host_wr(input logic s, input logic [7:0] d);
    cs = 1'b1; we = 1'b1; sel = s; wd = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic host_rd(input logic s, output logic [7:0] q);
    cs = 1'b1; we = 1'b0; sel = s;
    #1 q = rd_q;
    cs = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // table walk: R3 R5 R7 R8 R10 R11
    for (int i = 0; i < 11; i++) begin
      {cs, we, sel, wd, rdy, mode} = VEC[i][22:10];
      @(negedge clk);
      chk($sformatf("R5 row %0d strobe", i), {7'd0, stb}, {7'd0, VEC[i][9]});
      chk($sformatf("R7 R8 row %0d irq", i), {7'd0, irq}, {7'd0, VEC[i][8]});
      chk($sformatf("R10 row %0d prn_data", i), pd, VEC[i][7:0]);
    end
    cs = 1'b0; we = 1'b0; rdy = 1'b0;

    do_reset();
    host_rd(1'b0, v); chk("R1 status after reset", v, 8'h81);
    host_rd(1'b1, v); chk("R1 buffer after reset", v, 8'h00);
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);
    chk("R1 strobe after reset", {7'd0, stb}, 8'h00);
    chk("R1 prn_data after reset", pd, 8'h00);

    cs = 1'b0; we = 1'b0; sel = 1'b0; #1;
    chk("R9 idle bus", rd_q, 8'h00);
    cs = 1'b0; we = 1'b1; sel = 1'b1; wd = 8'hAA;
    @(negedge clk); we = 1'b0;
    host_rd(1'b1, v); chk("R9 deselected write", v, 8'h00);
    host_rd(1'b0, v); chk("R9 status untouched", v, 8'h81);

    host_wr(1'b0, 8'h3C);
    host_rd(1'b0, v); chk("R11 status write ignored", v, 8'h81);

    mode = 1'b1; rdy = 1'b0;
    host_wr(1'b1, 8'h96);
    host_rd(1'b0, v); chk("R3 status busy", v, 8'h00);
    host_rd(1'b1, v); chk("R2 buffer readback", v, 8'h96);
    repeat (3) begin
      @(negedge clk);
      chk("R4 no strobe while not ready", {7'd0, stb}, 8'h00);
      host_rd(1'b0, v); chk("R4 status stays busy", v, 8'h00);
    end
    rdy = 1'b1;
    @(negedge clk);
    rdy = 1'b0;
    chk("R5 strobe high", {7'd0, stb}, 8'h01);
    chk("R5 prn_data", pd, 8'h96);
    host_rd(1'b0, v); chk("R6 status ready", v, 8'h81);
    chk("R7 irq raised", {7'd0, irq}, 8'h01);
    @(negedge clk);
    chk("R5 strobe one cycle", {7'd0, stb}, 8'h00);
    repeat (3) @(negedge clk);
    chk("R7 irq held", {7'd0, irq}, 8'h01);
    chk("R10 prn_data held", pd, 8'h96);

    host_wr(1'b1, 8'h21);
    chk("R7 irq cleared by write", {7'd0, irq}, 8'h00);
    mode = 1'b0; rdy = 1'b1;
    @(negedge clk);
    rdy = 1'b0;
    chk("R8 strobe in polling", {7'd0, stb}, 8'h01);
    chk("R8 prn_data", pd, 8'h21);
    repeat (3) @(negedge clk);
    chk("R8 no irq in polling", {7'd0, irq}, 8'h00);

    host_wr(1'b1, 8'h55);
    host_wr(1'b1, 8'h66);
    host_rd(1'b1, v); chk("R11 busy write dropped", v, 8'h55);
    rdy = 1'b1;
    @(negedge clk);
    rdy = 1'b0;
    chk("R11 pending char sent", pd, 8'h55);

    host_wr(1'b1, 8'h77);
    do_reset();
    host_rd(1'b0, v); chk("R1 reset mid transfer", v, 8'h81);
    chk("R1 prn_data cleared", pd, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule